// File: doc/BRIEF.md
# Dual-Clock Lane-Masked Pipelined RAM

This block is a simple dual-port synchronous memory. One port only writes and the other only reads. Each port runs on its own clock. The default array holds 4096 words of 36 bits. The depth is a parameter, and the address width follows from it.

A write needs both write selects high. It is further masked by four active-low lane enables. Each lane is nine bits wide. It holds one byte from the low 32 data bits plus one of the four top bits. Lanes whose enable is high keep their old contents.

The read port samples its address while its select is high. The selected word lands in an output register, so data appears one read-clock edge later. With the select low, that register holds its value. A synchronous active-low reset, sampled on the read clock, clears only the output register. Reading and writing the same address in overlapping windows returns undefined data, and the surrounding logic must avoid it.

Top module: `lane_ram_top`

## Requirements
- R1: On a rising read-clock edge with `rst_n` low, `rd_data` becomes all zeros.
- R2: With `wr_sel_a` and `wr_sel_b` both 1 and all four `wr_lane_n` bits 0, the whole 36-bit `wr_data` word is stored at `wr_addr` on the rising write-clock edge.
- R3: Lane k (k = 0..3) covers data bits 8k+7..8k together with bit 32+k. The lane is written only when `wr_lane_n[k]` is 0.
- R4: During a write, every bit of a lane whose `wr_lane_n` bit is 1 keeps its previous contents.
- R5: When either write select is 0, the edge leaves the array unchanged, whatever the lane enables are.
- R6: On a rising read-clock edge with `rd_sel` high and `rst_n` high, `rd_data` takes the word stored at `rd_addr`. The value is visible after that edge and not before it.
- R7: On a rising read-clock edge with `rd_sel` low, `rd_data` keeps its previous value, even while `rd_addr` changes.
- R8: Every one of the DEPTH addresses, with an address width of clog2(DEPTH), stores its word independently of all other addresses.
- R9: Asserting `rst_n` does not alter the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, rising edge |
| wr_sel_a | input | 1 | First write select, active high |
| wr_sel_b | input | 1 | Second write select, active high |
| wr_addr | input | AW | Write word address |
| wr_data | input | 36 | Write data word |
| wr_lane_n | input | 4 | Active-low lane write enables |
| rd_clk | input | 1 | Read clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output register (read clock) |
| rd_sel | input | 1 | Read select, active high |
| rd_addr | input | AW | Read word address |
| rd_data | output | 36 | Registered read data |

## Verification
A corrupted lane decode or a wrong select gate leaves the wrong bits in the array. This shows only when that address is later read, one read-clock edge after the read is sampled. For this reason, every write in the sweeps is followed by a read of the same word, which is compared against a model built from the lane rule. A fault in the output register shows at once, at the edge it affects. A hold fault shows as a change in `rd_data` while `rd_sel` is low. A latency fault shows as new data appearing one edge early or one edge late.

// File: rtl/lane_ram_pkg.sv
// Package: shared constants and the lane map for the lane-masked RAM.
// Assumes: each lane holds one byte from the low field plus one top bit.
package lane_ram_pkg;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;

    // Return the lane that owns a given data bit.
    function automatic int lane_of(input int bit_idx, input int lanes);
        if (bit_idx < lanes * BYTE_W)
            return bit_idx / BYTE_W;
        else
            return bit_idx - lanes * BYTE_W;
    endfunction
endpackage

// File: rtl/lane_ram_wmask.sv
// Module: expands the active-low lane enables and the two selects into a per-bit write mask.
// Assumes: WORD_W == LANES * 9; the mask is purely combinational.
module lane_ram_wmask
    import lane_ram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = LANES * LANE_W
) (
    input  logic              wr_sel_a,
    input  logic              wr_sel_b,
    input  logic [LANES-1:0]  wr_lane_n,
    output logic [WORD_W-1:0] bit_we
);
    logic wr_go;

    // Both selects must be high for any bit to be written.
    always_comb wr_go = wr_sel_a & wr_sel_b;

    // Map each data bit to its owning lane enable.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign bit_we[b] = wr_go & ~wr_lane_n[lane_of(b, LANES)];
    end

    // R3: every enabled lane contributes exactly nine mask bits.
    always_comb begin
        lane_count_chk : assert ($countones(bit_we) ==
            (wr_go ? LANE_W * (LANES - $countones(wr_lane_n)) : 0));
    end
endmodule

// File: rtl/lane_ram_array.sv
// Module: storage array with a bitwise-masked write on the write clock and an unregistered read path.
// Assumes: DEPTH is a power of two; the caller keeps reads and writes of one address apart in time.
module lane_ram_array #(
    parameter int DEPTH  = 4096,
    parameter int WORD_W = 36,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] bit_we,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Write only the bits whose mask bit is set.
    always_ff @(posedge wr_clk) begin
        for (int b = 0; b < WORD_W; b++) begin
            if (bit_we[b])
                mem[wr_addr][b] <= wr_data[b];
        end
    end

    // Present the addressed word to the output register.
    always_comb rd_word = mem[rd_addr];

    // R2
    wr_take_chk : assert property (@(posedge wr_clk) disable iff (!rst_n)
        (|bit_we) |=> (((mem[$past(wr_addr)] ^ $past(wr_data)) & $past(bit_we)) == '0));

    // R4
    wr_keep_chk : assert property (@(posedge wr_clk) disable iff (!rst_n)
        (|bit_we) |=> (((mem[$past(wr_addr)] ^ $past(mem[wr_addr])) & ~$past(bit_we)) == '0));
endmodule

// File: rtl/lane_ram_rdreg.sv
// Module: read output register with select-gated load and synchronous active-low reset.
// Assumes: word_in is stable around the rising read-clock edge.
module lane_ram_rdreg #(
    parameter int WORD_W = 36
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rd_data
);
    // Load on select, hold otherwise, clear on reset.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_sel)
            rd_data <= word_in;
    end

    // R1
    rd_rst_chk : assert property (@(posedge rd_clk)
        !rst_n |=> (rd_data == '0));

    // R6
    rd_lat_chk : assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_sel |=> (rd_data == $past(word_in)));

    // R7
    rd_hold_chk : assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_sel |=> $stable(rd_data));
endmodule

// File: rtl/lane_ram_top.sv
// Module: dual-clock lane-masked RAM; one write port, one registered read port.
// Assumes: the two clocks are unrelated; same-address overlap is avoided by the user.
module lane_ram_top
    import lane_ram_pkg::*;
#(
    parameter int DEPTH  = 4096,
    parameter int LANES  = 4,
    localparam int WORD_W = LANES * LANE_W,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_sel_a,
    input  logic              wr_sel_b,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lane_n,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] bit_we;
    logic [WORD_W-1:0] rd_word;

    lane_ram_wmask #(.LANES(LANES), .WORD_W(WORD_W)) u_wmask (
        .wr_sel_a (wr_sel_a),
        .wr_sel_b (wr_sel_b),
        .wr_lane_n(wr_lane_n),
        .bit_we   (bit_we)
    );

    lane_ram_array #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_array (
        .wr_clk (wr_clk),
        .rst_n  (rst_n),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bit_we (bit_we),
        .rd_addr(rd_addr),
        .rd_word(rd_word)
    );

    lane_ram_rdreg #(.WORD_W(WORD_W)) u_rdreg (
        .rd_clk (rd_clk),
        .rst_n  (rst_n),
        .rd_sel (rd_sel),
        .word_in(rd_word),
        .rd_data(rd_data)
    );

    // R5
    wr_gate_chk : assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(wr_sel_a && wr_sel_b) |-> (bit_we == '0));
endmodule

// File: tb/test_lane_ram_top.sv
module test_lane_ram_top;
    localparam int DEPTH = 64;
    localparam int LANES = 4;
    localparam int W     = 36;
    localparam int AW    = $clog2(DEPTH);

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_sel_a = 1'b0, wr_sel_b = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [3:0]    wr_lane_n = 4'hF;
    logic          rst_n = 1'b0, rd_sel = 1'b0;
    logic [W-1:0]  rd_data;
    logic [W-1:0]  model [DEPTH];
    int            n_chk = 0, n_fail = 0;
    logic [W-1:0]  got, held;

    lane_ram_top #(.DEPTH(DEPTH), .LANES(LANES)) i_lane_ram_top (
        .wr_clk(wr_clk), .wr_sel_a(wr_sel_a), .wr_sel_b(wr_sel_b),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_n(wr_lane_n),
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_sel(rd_sel),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // 250 MHz write clock; read clock at the same rate, offset by 1 ns.
    always #2 wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #2 rd_clk = ~rd_clk;
    end

    function automatic logic [W-1:0] pat(input int a, input int k);
        return 36'(a * 36'h9_1357_2469 + k * 36'h1_0F0F_0F0F + 36'h5_A5A5_0001);
    endfunction

    // Bit mask of the lanes enabled (active low) computed from the lane rule.
    function automatic logic [W-1:0] lane_mask(input logic [3:0] en_n);
        logic [W-1:0] m = '0;
        for (int k = 0; k < 4; k++)
            if (!en_n[k]) begin
                m[8*k +: 8] = 8'hFF;
                m[32+k] = 1'b1;
            end
        return m;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [W-1:0] d, input logic [3:0] en_n,
                            input logic sa, input logic sb);
        @(negedge wr_clk);
        wr_addr = AW'(a); wr_data = d; wr_lane_n = en_n;
        wr_sel_a = sa; wr_sel_b = sb;
        @(posedge wr_clk); #1;
        wr_sel_a = 1'b0; wr_sel_b = 1'b0; wr_lane_n = 4'hF;
        if (sa && sb)
            model[a] = (model[a] & ~lane_mask(en_n)) | (d & lane_mask(en_n));
    endtask

    task automatic do_read(input int a, output logic [W-1:0] q);
        @(negedge rd_clk);
        rd_addr = AW'(a); rd_sel = 1'b1;
        @(posedge rd_clk); #1;
        rd_sel = 1'b0;
        q = rd_data;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset clears the output register
        repeat (3) @(posedge rd_clk);
        #1;
        check("R1", rd_data, '0);
        @(negedge rd_clk);
        rst_n = 1'b1;

        // R2, R8: full-word sweep over every address
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a, 0), 4'h0, 1'b1, 1'b1);
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, got);
            check("R2/R8 sweep", got, model[a]);
        end

        // R3, R4: every enable combination on fresh addresses
        for (int c = 0; c < 16; c++) begin
            do_write(c, ~pat(c, 7), 4'(c), 1'b1, 1'b1);
            do_read(c, got);
            check("R3/R4 lane combo", got, model[c]);
        end
        // R3: single-lane writes of ones over zeros show the exact lane bits
        for (int k = 0; k < 4; k++) begin
            do_write(20 + k, '0, 4'h0, 1'b1, 1'b1);
            do_write(20 + k, '1, ~(4'b1 << k), 1'b1, 1'b1);
            do_read(20 + k, got);
            check("R3 lane map", got, (36'hFF << (8*k)) | (36'b1 << (32+k)));
        end

        // R5: any missing write select blocks the write
        for (int s = 0; s < 3; s++) begin
            do_write(40, ~model[40], 4'h0, s[0], s[1]);
            do_read(40, got);
            check("R5 select gate", got, model[40]);
        end

        // R6: new data appears only after the sampling edge
        do_read(5, got);
        @(negedge rd_clk);
        rd_addr = AW'(6); rd_sel = 1'b1;
        #1;
        check("R6 before edge", rd_data, model[5]);
        @(posedge rd_clk); #1;
        rd_sel = 1'b0;
        check("R6 after edge", rd_data, model[6]);

        // R7: output holds while the read select is low
        held = rd_data;
        for (int a = 30; a < 34; a++) begin
            @(negedge rd_clk);
            rd_addr = AW'(a);
            @(posedge rd_clk); #1;
            check("R7 hold", rd_data, held);
        end

        // R9: reset clears the output but not the array
        @(negedge rd_clk); rst_n = 1'b0;
        @(posedge rd_clk); #1;
        check("R1 second reset", rd_data, '0);
        @(negedge rd_clk); rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a += 9) begin
            do_read(a, got);
            check("R9 contents kept", got, model[a]);
        end

        // R8: second pass with rotating lane masks over all addresses
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a, 3), 4'(a % 16), 1'b1, 1'b1);
        for (int a = DEPTH - 1; a >= 0; a--) begin
            do_read(a, got);
            check("R8 second pass", got, model[a]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule